// File: doc/BRIEF.md
# Dual Serial-Port FIFO with Fill-Level Requests

This block holds two independent queues that sit between a processor or DMA register port and a serial shift engine. The transmit queue is written by the processor or DMA side and drained by the shift engine. The receive queue is filled by the shift engine and drained by the processor or DMA side. Each queue stores up to `DEPTH` words, 16 by default.

Each queue reports how full it is. The transmit side reports its number of free slots, and the receive side reports its number of stored words. Each queue also raises a level-sensitive transfer request when that figure reaches a threshold chosen by a 3-bit code. The request is withdrawn in the first cycle that the figure falls below the threshold. This happens even if the queue is neither empty nor full.

Writing to a full queue, or reading from an empty one, sets one of four sticky error flags. Each flag stays set until software writes a one to clear it. A synchronous reset restores the block to its empty state. Two flush inputs can each empty one queue on its own, without affecting the other.

Top module: `sfifo_pair`

## Requirements
- R1: Each queue holds at most `DEPTH` (16) words. `tx_free` and `rx_used` always lie between 0 and 16.
- R2: The watermark code selects a threshold as follows: `3'b100` gives DEPTH/4 (4), `3'b101` gives DEPTH/2 (8), `3'b110` gives 3·DEPTH/4 (12), and `3'b111` gives DEPTH (16). Every other code, including `3'b000` and the reserved codes `001`, `010` and `011`, gives 1.
- R3: `rx_req` is high exactly while `rx_used` is at or above the threshold chosen by `rx_wm`.
- R4: `tx_req` is high exactly while `tx_free` is at or above the threshold chosen by `tx_wm`.
- R5: `tx_free` and `rx_used` change in the cycle after a push or pop. A push and a pop in the same cycle, on a queue that is neither empty nor full, leave the count unchanged.
- R6: A push to a full queue is discarded and sets that queue's overflow flag. The flag bits are: `err[0]` transmit overflow, `err[1]` transmit underflow, `err[2]` receive overflow, `err[3]` receive underflow.
- R7: A pop from an empty queue leaves the pointers and count unchanged, returns zero on its read-data output in the next cycle, and sets that queue's underflow flag.
- R8: Each error flag stays set until a one is written to the same bit of `err_clr`. If a flag is set and cleared in the same cycle, the set wins.
- R9: Reset empties both queues and clears all flags. A flush empties only its own queue in the next cycle, takes priority over a push or pop in the same cycle, and raises no error.
- R10: Words leave each queue in the order they were accepted. Popped data appears on the read-data output one cycle after the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_flush | input | 1 | Empties the transmit queue |
| rx_flush | input | 1 | Empties the receive queue |
| tx_push | input | 1 | Processor/DMA writes a word into the transmit queue |
| tx_wdata | input | DW | Transmit write data |
| tx_pop | input | 1 | Shift engine takes a word from the transmit queue |
| tx_rdata | output | DW | Transmit word, valid the cycle after `tx_pop` |
| tx_wm | input | 3 | Transmit watermark code |
| tx_free | output | $clog2(DEPTH+1) | Free transmit slots |
| tx_req | output | 1 | Transmit refill request |
| rx_push | input | 1 | Shift engine delivers a word into the receive queue |
| rx_wdata | input | DW | Receive write data |
| rx_pop | input | 1 | Processor/DMA reads a word from the receive queue |
| rx_rdata | output | DW | Receive word, valid the cycle after `rx_pop` |
| rx_wm | input | 3 | Receive watermark code |
| rx_used | output | $clog2(DEPTH+1) | Stored receive words |
| rx_req | output | 1 | Receive drain request |
| err_clr | input | 4 | Write-one-to-clear for the error flags |
| err | output | 4 | Sticky error flags (bit map in R6) |

## Verification
The bench builds the block with its defaults, `DW` = 8 and `DEPTH` = 16. With a 16-word queue, all four non-unit thresholds (4, 8, 12, 16) are reached, and so is the exact full boundary where an overflow begins. A reference queue in the bench predicts every count, request level, flag and popped word on each cycle. The watermark codes are swept while the level rises and falls through each threshold.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;

  // Bit positions of the sticky error vector
  localparam int ERR_TX_OVF = 0;
  localparam int ERR_TX_UNF = 1;
  localparam int ERR_RX_OVF = 2;
  localparam int ERR_RX_UNF = 3;
  localparam int ERR_W      = 4;

  // Threshold selected by a watermark code; reserved codes fall back to 1
  function automatic int wm_level(input logic [2:0] code, input int depth);
    case (code)
      3'b100:  return depth / 4;
      3'b101:  return depth / 2;
      3'b110:  return (3 * depth) / 4;
      3'b111:  return depth;
      default: return 1;
    endcase
  endfunction

  // Next pointer value with wrap for any depth
  function automatic int ptr_step(input int p, input int depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/sfifo_queue.sv
module sfifo_queue #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [CW-1:0] count,
  output logic          ovf_evt,
  output logic          unf_evt
);
  import sfifo_pkg::*;

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, empty, do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !flush && !full;
  assign do_pop  = pop  && !flush && !empty;
  assign ovf_evt = push && !flush && full;
  assign unf_evt = pop  && !flush && empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
      rdata <= '0;
    end else if (flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (do_push) wp <= AW'(ptr_step(int'(wp), DEPTH));
      if (do_pop) begin
        rdata <= mem[rp];
        rp    <= AW'(ptr_step(int'(rp), DEPTH));
      end else if (unf_evt) begin
        rdata <= '0;
      end
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R1: occupancy never exceeds the depth
  p_count_bound_r1: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  // R6: a rejected push leaves the queue full
  p_ovf_drop_r6: assert property (@(posedge clk) disable iff (rst)
    ovf_evt && !pop |=> count == CW'(DEPTH));

  // R7: a pop on empty returns zero and moves nothing
  p_unf_zero_r7: assert property (@(posedge clk) disable iff (rst)
    unf_evt && !push |=> rdata == '0 && count == '0);

  // R5: balanced push and pop keep the level
  p_pushpop_r5: assert property (@(posedge clk) disable iff (rst)
    push && pop && !flush && !full && !empty |=> $stable(count));

  // R9: flush empties the queue next cycle
  p_flush_r9: assert property (@(posedge clk) disable iff (rst)
    flush |=> count == '0);

endmodule

// File: rtl/sfifo_wm_req.sv
module sfifo_wm_req #(
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [2:0]    code,
  input  logic [CW-1:0] level,
  output logic          req
);
  import sfifo_pkg::*;

  logic [CW-1:0] thr;

  assign thr = CW'(wm_level(code, DEPTH));
  assign req = (level >= thr);

endmodule

// File: rtl/sfifo_errs.sv
module sfifo_errs #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);

  always_ff @(posedge clk) begin
    if (rst) flags <= '0;
    else     flags <= (flags & ~clr) | set;
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R8: a flag holds until cleared
    p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
      flags[i] && !clr[i] |=> flags[i]);
    // R8: a set in the same cycle as a clear wins
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> flags[i]);
  end

endmodule

// File: rtl/sfifo_pair.sv
module sfifo_pair #(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tx_flush,
  input  logic          rx_flush,
  input  logic          tx_push,
  input  logic [DW-1:0] tx_wdata,
  input  logic          tx_pop,
  output logic [DW-1:0] tx_rdata,
  input  logic [2:0]    tx_wm,
  output logic [CW-1:0] tx_free,
  output logic          tx_req,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_wdata,
  input  logic          rx_pop,
  output logic [DW-1:0] rx_rdata,
  input  logic [2:0]    rx_wm,
  output logic [CW-1:0] rx_used,
  output logic          rx_req,
  input  logic [3:0]    err_clr,
  output logic [3:0]    err
);
  import sfifo_pkg::*;

  logic [CW-1:0]    tx_count;
  logic             tx_ovf_evt, tx_unf_evt, rx_ovf_evt, rx_unf_evt;
  logic [ERR_W-1:0] err_set;

  sfifo_queue #(.DW(DW), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst(rst), .flush(tx_flush),
    .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_rdata),
    .count(tx_count), .ovf_evt(tx_ovf_evt), .unf_evt(tx_unf_evt)
  );

  sfifo_queue #(.DW(DW), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst(rst), .flush(rx_flush),
    .push(rx_push), .wdata(rx_wdata), .pop(rx_pop), .rdata(rx_rdata),
    .count(rx_used), .ovf_evt(rx_ovf_evt), .unf_evt(rx_unf_evt)
  );

  assign tx_free = CW'(DEPTH) - tx_count;

  sfifo_wm_req #(.DEPTH(DEPTH)) u_tx_req (.code(tx_wm), .level(tx_free), .req(tx_req));
  sfifo_wm_req #(.DEPTH(DEPTH)) u_rx_req (.code(rx_wm), .level(rx_used), .req(rx_req));

  always_comb begin
    err_set             = '0;
    err_set[ERR_TX_OVF] = tx_ovf_evt;
    err_set[ERR_TX_UNF] = tx_unf_evt;
    err_set[ERR_RX_OVF] = rx_ovf_evt;
    err_set[ERR_RX_UNF] = rx_unf_evt;
  end

  sfifo_errs #(.N(ERR_W)) u_errs (.clk(clk), .rst(rst), .set(err_set), .clr(err_clr), .flags(err));

  // R3: a full receive queue always requests draining
  p_rx_full_req_r3: assert property (@(posedge clk) disable iff (rst)
    rx_used == CW'(DEPTH) |-> rx_req);

  // R3: an empty receive queue never requests
  p_rx_empty_idle_r3: assert property (@(posedge clk) disable iff (rst)
    rx_used == '0 |-> !rx_req);

  // R4: a full transmit queue never requests refill
  p_tx_full_idle_r4: assert property (@(posedge clk) disable iff (rst)
    tx_free == '0 |-> !tx_req);

  // R1: free slots never exceed the depth
  p_tx_free_bound_r1: assert property (@(posedge clk) disable iff (rst)
    tx_free <= CW'(DEPTH));

endmodule

// File: tb/tb_sfifo_pair.sv
module tb_sfifo_pair;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int DEPTH = 16;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst = 1;
  logic tx_flush = 0, rx_flush = 0, tx_push = 0, tx_pop = 0, rx_push = 0, rx_pop = 0;
  logic [DW-1:0] tx_wdata = 0, rx_wdata = 0, tx_rdata, rx_rdata;
  logic [2:0] tx_wm = 0, rx_wm = 0;
  logic [CW-1:0] tx_free, rx_used;
  logic tx_req, rx_req;
  logic [3:0] err_clr = 0, err;

  sfifo_pair #(.DW(DW), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .tx_flush(tx_flush), .rx_flush(rx_flush),
    .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
    .tx_wm(tx_wm), .tx_free(tx_free), .tx_req(tx_req),
    .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
    .rx_wm(rx_wm), .rx_used(rx_used), .rx_req(rx_req),
    .err_clr(err_clr), .err(err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [DW-1:0] txq[$], rxq[$];
  logic [3:0] err_m = 0;
  bit tx_pend = 0, rx_pend = 0, live = 0;
  logic [DW-1:0] tx_exp = 0, rx_exp = 0;

  function automatic int thr(input logic [2:0] c);
    if (c == 3'b111) return 16;
    if (c == 3'b110) return 12;
    if (c == 3'b101) return 8;
    if (c == 3'b100) return 4;
    return 1;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model, updated at the clock edge from stable inputs
  always @(posedge clk) begin : model
    int ts, rs;
    logic [3:0] st;
    if (rst) begin
      txq.delete(); rxq.delete(); err_m = 0; tx_pend = 0; rx_pend = 0; live = 1;
    end else begin
      ts = txq.size(); rs = rxq.size(); st = 0;
      tx_pend = tx_pop && !tx_flush;
      rx_pend = rx_pop && !rx_flush;
      if (tx_flush) txq.delete();
      else begin
        if (tx_pop) begin
          if (ts == 0) begin tx_exp = 0; st[1] = 1; end else tx_exp = txq.pop_front();
        end
        if (tx_push) begin
          if (ts == DEPTH) st[0] = 1; else txq.push_back(tx_wdata);
        end
      end
      if (rx_flush) rxq.delete();
      else begin
        if (rx_pop) begin
          if (rs == 0) begin rx_exp = 0; st[3] = 1; end else rx_exp = rxq.pop_front();
        end
        if (rx_push) begin
          if (rs == DEPTH) st[2] = 1; else rxq.push_back(rx_wdata);
        end
      end
      err_m = (err_m & ~err_clr) | st;
    end
  end

  // Monitor: compares outputs mid-cycle against the model
  always @(negedge clk) begin
    if (live) begin
      chk(rx_used <= DEPTH && tx_free <= DEPTH, "R1 occupancy bound", rx_used, DEPTH);
      chk(tx_free == DEPTH - txq.size(), "R5 tx_free", tx_free, DEPTH - txq.size());
      chk(rx_used == rxq.size(), "R5 rx_used", rx_used, rxq.size());
      chk(rx_req == (rxq.size() >= thr(rx_wm)), "R2/R3 rx_req", rx_req, rxq.size() >= thr(rx_wm));
      chk(tx_req == ((DEPTH - txq.size()) >= thr(tx_wm)), "R4 tx_req", tx_req,
          (DEPTH - txq.size()) >= thr(tx_wm));
      chk(err == err_m, "R6/R7/R8 err flags", err, err_m);
      if (tx_pend) chk(tx_rdata == tx_exp, "R10/R7 tx_rdata", tx_rdata, tx_exp);
      if (rx_pend) chk(rx_rdata == rx_exp, "R10/R7 rx_rdata", rx_rdata, rx_exp);
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
    tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
    tx_flush = 0; rx_flush = 0; err_clr = 0;
  endtask

  task automatic put_tx(input logic [DW-1:0] d); tx_push = 1; tx_wdata = d; cyc(); endtask
  task automatic put_rx(input logic [DW-1:0] d); rx_push = 1; rx_wdata = d; cyc(); endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    chk(tx_free == DEPTH && rx_used == 0 && err == 0, "R9 reset state", rx_used, 0);

    // Transmit fill past full, sweeping its watermark code
    for (int i = 0; i < DEPTH + 1; i++) begin
      tx_wm = 3'(i);
      put_tx(8'(8'h30 + i));
    end
    chk(err[0] == 1, "R6 tx overflow flag", err[0], 1);
    for (int i = 0; i < DEPTH + 1; i++) begin
      tx_wm = 3'(i + 3);
      tx_pop = 1; cyc();
    end
    @(negedge clk);
    chk(err[1] == 1 && tx_rdata == 0, "R7 tx underflow", tx_rdata, 0);
    err_clr = 4'b0001; cyc();
    err_clr = 4'b0010; cyc();

    // Receive level sweep through every code
    for (int c = 0; c < 8; c++) begin
      rx_wm = 3'(c);
      for (int i = 0; i < DEPTH; i++) put_rx(8'(c * 16 + i));
      put_rx(8'hEE);
      for (int i = 0; i < DEPTH; i++) begin rx_pop = 1; cyc(); end
      rx_pop = 1; cyc();
    end
    err_clr = 4'b1100; cyc();

    // Balanced push and pop at a mid level, R5
    rx_wm = 3'b101;
    for (int i = 0; i < 8; i++) put_rx(8'(i + 100));
    for (int i = 0; i < 6; i++) begin
      rx_push = 1; rx_wdata = 8'(i + 200); rx_pop = 1; cyc();
    end
    @(negedge clk);
    chk(rx_used == 8, "R5 balanced push/pop", rx_used, 8);

    // Independent flush with competing push, R9
    for (int i = 0; i < 5; i++) put_tx(8'(i + 60));
    rx_flush = 1; rx_push = 1; rx_wdata = 8'h55; cyc();
    @(negedge clk);
    chk(rx_used == 0 && tx_free == DEPTH - 5 && err == 0, "R9 rx flush isolated", rx_used, 0);
    tx_flush = 1; tx_pop = 1; cyc();
    @(negedge clk);
    chk(tx_free == DEPTH && err == 0, "R9 tx flush no error", tx_free, DEPTH);

    // Set wins over clear in the same cycle, R8
    for (int i = 0; i < DEPTH; i++) put_rx(8'(i));
    rx_push = 1; err_clr = 4'b0100; cyc();
    @(negedge clk);
    chk(err[2] == 1, "R8 set beats clear", err[2], 1);
    err_clr = 4'b0100; cyc();
    @(negedge clk);
    chk(err == 0, "R8 write-one clears", err, 0);
    for (int i = 0; i < DEPTH; i++) begin rx_pop = 1; cyc(); end
    repeat (2) cyc();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule